// File: doc/BRIEF.md
# Continuous-Conversion Timing Sequencer with Active-Low Data-Ready

This block reproduces the digital conversion timing of a delta-sigma converter. Every clock cycle stands for one modulator period. A cycle counter times each conversion. The counter's limit comes from a data-rate field in a small configuration bank. The block drives an active-low data-ready line (`drdy_n`) and publishes a result word. The result word is a count of completed conversions, which stands in for real sample data.

Its inputs are single-cycle strobes that the serial front end has already decoded: start/sync, reset and powerdown commands, a write-complete strobe, and a data-read strobe. The write-complete strobe marks the last serial clock edge of a register write and carries that write's address and data. The synchronous reset input plays the part of a power-on reset.

A result that is never read keeps the line low. At the next completion the line then gives only a short high pulse. Any register write made while converting moves the conversion grid, so the next result is timed from that write.

Top module: `cvt_sequencer`

## Requirements
- R1: The conversion length is P = 16*(rate+2) clock cycles, where rate is register 0 bits [1:0] (32, 48, 64 or 80 cycles). While continuous mode runs undisturbed, successive falling edges of `drdy_n` are exactly P cycles apart.
- R2: Let a start strobe be sampled at edge E. Then `drdy_n` falls after edge E+P, and every fall follows a completion.
- R3: A `data_rd` strobe while `drdy_n` is low, outside a completion cycle, sets `drdy_n` high after that edge. The line then stays high until the next completion.
- R4: When a result is left unread, `drdy_n` goes high for exactly the 2 cycles before the next completion and then returns low.
- R5: A `data_rd` strobe in the same cycle as a completion is ignored, so `drdy_n` goes low and stays low.
- R6: A start strobe during a conversion abandons it and times a new conversion from the strobe. A restart in the last cycle of a conversion suppresses that completion, which delays the result by at most one period.
- R7: A configuration write to any address during a conversion restarts timing from the write strobe, using the rate just written.
- R8: A configuration write while idle stores its data and starts no conversion.
- R9: Reset and powerdown commands stop conversions and drive `drdy_n` high. Reset also restores the register defaults, while powerdown keeps the register contents. Only a start strobe resumes conversions.
- R10: On power-on reset every register takes its default: register 0 = 0x04 (continuous mode at register 0 bit 2, rate 0), and the others 0x00. `drdy_n` is high during reset. One conversion then completes 32 cycles after the last reset edge, and no further conversion follows.
- R11: With register 0 bit 2 clear (single mode), a start strobe gives exactly one conversion.
- R12: `result` is cleared by power-on reset and increments by one at each completion.
- R13: `cfg_rdata` shows the register addressed by `cfg_raddr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cmd_start | input | 1 | Start/sync command strobe |
| cmd_reset | input | 1 | Reset command strobe |
| cmd_pdown | input | 1 | Powerdown command strobe |
| cfg_wr | input | 1 | Register write complete (last serial edge) |
| cfg_waddr | input | 2 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| cfg_raddr | input | 2 | Register read address |
| cfg_rdata | output | 8 | Registered register read data |
| data_rd | input | 1 | Result read strobe |
| drdy_n | output | 1 | Active-low data ready |
| result | output | 8 | Latest result word (completion count) |

## Verification
The embedded assertions check the following on every cycle:
- the conversion counter stays below the selected period;
- every falling edge of `drdy_n` comes from a completion;
- a read that coincides with a completion leaves the line low;
- the stop commands raise the line and halt timing;
- a single-mode conversion ends the run;
- the result word steps by exactly one.

Only the bench scenarios can show the absolute spacing of the edges. These include the period at each of the four rates, the 2-cycle pulse before an unread completion, the one-period delay from a late restart, the single conversion after power-on reset, and the silence after idle writes.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

  // Field placement inside configuration register 0
  localparam int unsigned RATE_LSB = 0;
  localparam int unsigned CONT_POS = 2;

  // Conversion length in modulator cycles for a rate index
  function automatic int unsigned period_cycles(input int unsigned unit,
                                                input int unsigned rate);
    return unit * (rate + 2);
  endfunction

endpackage

// File: rtl/cvt_cfg_bank.sv
module cvt_cfg_bank #(
  parameter int unsigned DW     = 8,
  parameter int unsigned NREG   = 4,
  parameter int unsigned RATE_W = 2,
  parameter logic [DW-1:0] DEF0 = 8'h04
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_i,
  input  logic                    we_i,
  input  logic [$clog2(NREG)-1:0] waddr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [$clog2(NREG)-1:0] raddr_i,
  output logic [DW-1:0]           rdata_o,
  output logic [RATE_W-1:0]       rate_o,
  output logic                    cont_o
);
  localparam int unsigned AW = $clog2(NREG);

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] DEFV = (g == 0) ? DEF0 : '0;
    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        regs[g] <= DEFV;
      end else if (we_i && (waddr_i == AW'(g))) begin
        regs[g] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    rdata_o <= regs[raddr_i];
  end

  assign rate_o = regs[0][cvt_pkg::RATE_LSB +: RATE_W];
  assign cont_o = regs[0][cvt_pkg::CONT_POS];

  AST_CLR_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (regs[0] == DEF0)); // R9
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
    (we_i && !clr_i) |=> (regs[$past(waddr_i)] == $past(wdata_i))); // R8

endmodule

// File: rtl/cvt_timer.sv
module cvt_timer #(
  parameter int unsigned RATE_W = 2,
  parameter int unsigned UNIT   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              restart_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              cont_i,
  output logic              done_o,
  output logic              pre_o
);
  localparam int unsigned NRATE = 1 << RATE_W;
  localparam int unsigned PMAX  = UNIT * (NRATE + 1);
  localparam int unsigned CW    = $clog2(PMAX + 1);

  logic [CW-1:0] ptab [NRATE];
  logic [CW-1:0] period, last_c, pre_c, cnt;
  logic          running, once, hold;

  for (genvar g = 0; g < NRATE; g++) begin : g_rate
    assign ptab[g] = CW'(cvt_pkg::period_cycles(UNIT, g));
  end

  assign period = ptab[rate_i];
  assign last_c = period - CW'(1);
  assign pre_c  = period - CW'(3);
  assign hold   = stop_i | start_i | restart_i;
  assign done_o = running && !hold && (cnt == last_c);
  assign pre_o  = running && !hold && (cnt == pre_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b1;
      once    <= 1'b1;
      cnt     <= '0;
    end else if (stop_i) begin
      running <= 1'b0;
      once    <= 1'b0;
      cnt     <= '0;
    end else if (start_i) begin
      running <= 1'b1;
      once    <= 1'b0;
      cnt     <= '0;
    end else if (restart_i && running) begin
      cnt <= '0;
    end else if (running) begin
      if (cnt == last_c) begin
        cnt <= '0;
        if (!cont_i || once) begin
          running <= 1'b0;
          once    <= 1'b0;
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt < period)); // R1
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !running); // R9
  AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
    (start_i && !stop_i) |=> (running && cnt == '0)); // R6
  AST_SINGLE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (done_o && !cont_i) |=> !running); // R11

endmodule

// File: rtl/cvt_rdy_ctl.sv
module cvt_rdy_ctl #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stop_i,
  input  logic          done_i,
  input  logic          pre_i,
  input  logic          rd_i,
  output logic          drdy_n_o,
  output logic [DW-1:0] result_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drdy_n_o <= 1'b1;
      result_o <= '0;
    end else if (stop_i) begin
      drdy_n_o <= 1'b1;
    end else if (done_i) begin
      drdy_n_o <= 1'b0;
      result_o <= result_o + DW'(1);
    end else if (pre_i || rd_i) begin
      drdy_n_o <= 1'b1;
    end
  end

  AST_RD_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    (done_i && rd_i && !stop_i) |=> !drdy_n_o); // R5
  AST_READ_RAISES: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !done_i) |=> drdy_n_o); // R3
  AST_RESULT_STEP: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (result_o == $past(result_o) + DW'(1))); // R12

endmodule

// File: rtl/cvt_sequencer.sv
module cvt_sequencer #(
  parameter int unsigned DW     = 8,
  parameter int unsigned NREG   = 4,
  parameter int unsigned RATE_W = 2,
  parameter int unsigned UNIT   = 16,
  parameter logic [DW-1:0] DEF0 = 8'h04
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_start,
  input  logic                    cmd_reset,
  input  logic                    cmd_pdown,
  input  logic                    cfg_wr,
  input  logic [$clog2(NREG)-1:0] cfg_waddr,
  input  logic [DW-1:0]           cfg_wdata,
  input  logic [$clog2(NREG)-1:0] cfg_raddr,
  output logic [DW-1:0]           cfg_rdata,
  input  logic                    data_rd,
  output logic                    drdy_n,
  output logic [DW-1:0]           result
);
  logic [RATE_W-1:0] rate;
  logic              cont, stop, done, pre;

  assign stop = cmd_reset | cmd_pdown;

  cvt_cfg_bank #(.DW(DW), .NREG(NREG), .RATE_W(RATE_W), .DEF0(DEF0)) u_bank (
    .clk(clk), .rst(rst), .clr_i(cmd_reset),
    .we_i(cfg_wr), .waddr_i(cfg_waddr), .wdata_i(cfg_wdata),
    .raddr_i(cfg_raddr), .rdata_o(cfg_rdata),
    .rate_o(rate), .cont_o(cont)
  );

  cvt_timer #(.RATE_W(RATE_W), .UNIT(UNIT)) u_timer (
    .clk(clk), .rst(rst), .start_i(cmd_start), .stop_i(stop),
    .restart_i(cfg_wr), .rate_i(rate), .cont_i(cont),
    .done_o(done), .pre_o(pre)
  );

  cvt_rdy_ctl #(.DW(DW)) u_rdy (
    .clk(clk), .rst(rst), .stop_i(stop), .done_i(done), .pre_i(pre),
    .rd_i(data_rd), .drdy_n_o(drdy_n), .result_o(result)
  );

  AST_FALL_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(drdy_n) |-> $past(done)); // R2
  AST_STOP_RAISES: assert property (@(posedge clk) disable iff (rst)
    stop |=> drdy_n); // R9

endmodule

// File: tb/test_cvt_sequencer.sv
module test_cvt_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 0, cmd_reset = 0, cmd_pdown = 0, cfg_wr = 0, data_rd = 0;
  logic [1:0] cfg_waddr = '0, cfg_raddr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata, result;
  logic drdy_n;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cvt_sequencer i_cvt_sequencer (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_reset(cmd_reset),
    .cmd_pdown(cmd_pdown), .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .data_rd(data_rd), .drdy_n(drdy_n), .result(result)
  );

  function automatic int per(input int r);
    return 16 * (r + 2);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // ticks until a high-to-low step of drdy_n; -1 if none within limit
  task automatic wait_fall(output int n, input int limit);
    logic prev;
    prev = drdy_n;
    n = 0;
    while (1) begin
      tick();
      n++;
      if (prev && !drdy_n) return;
      prev = drdy_n;
      if (n >= limit) begin
        n = -1;
        return;
      end
    end
  endtask

  // number of samples over n ticks where drdy_n differs from lvl
  task automatic hold_level(input int n, input logic lvl, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (drdy_n !== lvl) bad++;
    end
  endtask

  task automatic pulse_start();  cmd_start = 1; tick(); cmd_start = 0; endtask
  task automatic pulse_rd();     data_rd = 1;   tick(); data_rd = 0;   endtask
  task automatic pulse_pdown();  cmd_pdown = 1; tick(); cmd_pdown = 0; endtask
  task automatic pulse_creset(); cmd_reset = 1; tick(); cmd_reset = 0; endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    cfg_waddr = a; cfg_wdata = d; cfg_wr = 1;
    tick();
    cfg_wr = 0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    cfg_raddr = a;
    tick();
    d = cfg_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int n, bad, res0;
    logic [7:0] d;

    // R10: power-on reset, a single conversion at the default rate
    repeat (2) tick();
    chk(drdy_n === 1'b1, "R10 drdy high in reset", drdy_n, 1);
    tick();
    rst = 0;
    wait_fall(n, 300);
    chk(n == 32, "R10 first completion after reset", n, 32);
    chk(result == 8'd1, "R12 result after first completion", result, 1);
    hold_level(150, 1'b0, bad);
    chk(bad == 0, "R10 no further conversions", bad, 0);

    // R13: defaults seen through the read port
    for (int a = 0; a < 4; a++) begin
      read_reg(2'(a), d);
      chk(d == ((a == 0) ? 8'h04 : 8'h00), "R13 default readback", d, (a == 0) ? 4 : 0);
    end

    // R3: read raises the line
    pulse_rd();
    chk(drdy_n === 1'b1, "R3 read raises drdy", drdy_n, 1);

    // R2: start gives a completion after P cycles
    pulse_start();
    wait_fall(n, 300);
    chk(n == per(0), "R2 start to completion", n, per(0));
    res0 = result;

    // R7 / R1 / R12: sweep every rate via a write during conversion
    for (int r = 0; r < 4; r++) begin
      do_write(2'd0, 8'h04 | 8'(r));
      wait_fall(n, 300);
      chk(n == per(r), "R7 write restarts with new rate", n, per(r));
      wait_fall(n, 300);
      chk(n == per(r), "R1 continuous period", n, per(r));
      chk(result == 8'(res0 + 2 * (r + 1)), "R12 result step", result, res0 + 2 * (r + 1));
    end

    // R4: unread result, 2-cycle high pulse before next completion
    do_write(2'd0, 8'h04);
    wait_fall(n, 300);
    bad = 0;
    for (int k = 1; k <= 32; k++) begin
      tick();
      if (drdy_n !== ((k == 30) || (k == 31))) bad++;
    end
    chk(bad == 0, "R4 pulse shape mismatches", bad, 0);

    // R5: read at completion ignored; R3 line stays high until then
    pulse_rd();
    repeat (30) tick();
    chk(drdy_n === 1'b1, "R3 stays high until completion", drdy_n, 1);
    data_rd = 1;
    tick();
    data_rd = 0;
    chk(drdy_n === 1'b0, "R5 read at completion ignored", drdy_n, 0);
    tick();
    chk(drdy_n === 1'b0, "R5 still low after", drdy_n, 0);

    // R6: restart in the last cycle of a conversion
    // now one tick past the completion; move to the final cycle (k = 31)
    repeat (30) tick();
    pulse_start();
    chk(drdy_n === 1'b1, "R6 completion suppressed", drdy_n, 1);
    wait_fall(n, 300);
    chk(n == 32, "R6 completion after restart", n, 32);

    // R9 powerdown keeps registers; R8 idle write starts nothing
    pulse_pdown();
    chk(drdy_n === 1'b1, "R9 powerdown raises drdy", drdy_n, 1);
    do_write(2'd1, 8'h5A);
    hold_level(100, 1'b1, bad);
    chk(bad == 0, "R8 idle write starts nothing", bad, 0);
    read_reg(2'd1, d);
    chk(d == 8'h5A, "R9 powerdown keeps registers", d, 'h5A);
    pulse_start();
    wait_fall(n, 300);
    chk(n == 32, "R9 start resumes after powerdown", n, 32);

    // R9 reset command restores defaults and stops
    pulse_creset();
    hold_level(100, 1'b1, bad);
    chk(bad == 0, "R9 reset command stops", bad, 0);
    read_reg(2'd1, d);
    chk(d == 8'h00, "R9 reset restores reg1", d, 0);
    read_reg(2'd0, d);
    chk(d == 8'h04, "R9 reset restores reg0", d, 4);

    // R11: single mode, rate 1
    do_write(2'd0, 8'h01);
    pulse_start();
    wait_fall(n, 300);
    chk(n == per(1), "R11 single conversion time", n, per(1));
    pulse_rd();
    hold_level(150, 1'b1, bad);
    chk(bad == 0, "R11 no second conversion", bad, 0);

    summary();
    $finish;
  end
endmodule